// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Status Flags

A single-clock first-in first-out buffer that holds up to `DEPTH` words of `WIDTH` bits (18 by default). `DEPTH` is a power of two from 64 to 4096. A word is stored on a clock edge that has write enable set. A word is removed on an edge that has read enable set, and it appears on the read data port after that edge. The read data holds its value until the next accepted read.

Five active-low flags report the fill level, all registered: empty, almost-empty, half-full, almost-full and full. The almost-empty threshold `n` and the almost-full threshold `m` start at a value that depends on the depth. Either one can be replaced through a parallel offset-load port.

A rewind input moves the read side back to the oldest word that is still held in storage, so the stored stream can be read again. Words written afterwards follow the replayed data. Every flag is derived from the distance between the write and read positions, so the flags stay correct across a rewind.

Top module: `sfifo_pflag`

## Requirements
- R1: `empty_n` is 0 when the FIFO holds 0 words and 1 when it holds one or more.
- R2: `aempty_n` is 0 when the word count is at most `n` and 1 when it is above `n`.
- R3: `half_n` is 1 when the count is at most `DEPTH/2` and 0 when it is above.
- R4: `afull_n` is 0 when the count is at least `DEPTH-m` and 1 when it is below.
- R5: `full_n` is 0 exactly when the count equals `DEPTH`. A write while full is dropped, and the stored data and the count do not change.
- R6: A read while empty is dropped. `rd_data` keeps its value and the count stays 0.
- R7: Reset restores the default offsets: `n = m = DEPTH/8-1` for depths up to 512 (7 for 64, 31 for 256, 63 for 512) and 127 for depths of 1024 and above. It empties the FIFO, which leaves `empty_n = aempty_n = 0` and `half_n = afull_n = full_n = 1`, and it clears `rd_data` to 0.
- R8: With `ofs_ld = 1`, `ofs_val` is loaded into `n` when `ofs_sel = 0` and into `m` when `ofs_sel = 1`. The flags use the new value from that same edge on.
- R9: An accepted read places the oldest unread word on `rd_data` at the clock edge that takes it, in write order.
- R10: On an edge with `rewind = 1`, the read position moves to the oldest retained word. The retained words are the last `DEPTH` words written since reset, or all of them if fewer were written. A read requested on that edge is dropped. Later reads return the retained words in write order.
- R11: A write on or after a rewind edge is read out after the replayed words. Rewinding can be repeated and replays up to the full depth each time.
- R12: All flags are registered. They change on the same edge as the pointer, count or offset change that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Last word read |
| rewind | input | 1 | Move read side back to the oldest retained word |
| ofs_ld | input | 1 | Load an offset this edge |
| ofs_sel | input | 1 | 0: almost-empty offset n, 1: almost-full offset m |
| ofs_val | input | log2(DEPTH) | Offset value to load |
| empty_n | output | 1 | Low when empty |
| aempty_n | output | 1 | Low when count is at most n |
| half_n | output | 1 | Low when count is above DEPTH/2 |
| afull_n | output | 1 | Low when count is at least DEPTH-m |
| full_n | output | 1 | Low when full |

## Verification
Two pairs of operations can fall on the same edge. A rewind and a write can share an edge, and when the retained history already spans `DEPTH` words, that write moves the oldest retained position forward during the rewind. A write and a read can also share an edge while the FIFO is full or empty, and only the side the flags allow may proceed. The bench creates the first case directly after draining a full FIFO. It creates both cases at random, with rewinds and offset loads mixed into traffic that swings between empty and full. A reference model in the bench applies each rule to the state before the edge and compares every flag and the read word one cycle later.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

   typedef struct packed {
      logic empty_n;
      logic aempty_n;
      logic half_n;
      logic afull_n;
      logic full_n;
   } sfifo_flags_t;

   // Depth-dependent reset value of both thresholds
   function automatic int unsigned def_offset(input int unsigned depth);
      if (depth >= 1024) return 127;
      return depth / 8 - 1;
   endfunction

endpackage

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
   parameter int WIDTH = 18,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= store[raddr];
   end

endmodule

// File: rtl/sfifo_ptrs.sv
module sfifo_ptrs #(
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic        rewind,
   input  logic        full_n,
   input  logic        empty_n,
   output logic        wr_ok,
   output logic        rd_ok,
   output logic [AW:0] wptr,
   output logic [AW:0] rptr,
   output logic [AW:0] cnt_nx
);

   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
   localparam logic [AW:0] ONE      = (AW+1)'(1);

   logic [AW:0] org, org_nx, wptr_nx, rptr_nx;

   // Requests are judged on the registered flags (state before the edge)
   assign wr_ok = wr_en & full_n;
   assign rd_ok = rd_en & empty_n & ~rewind;

   always_comb begin
      wptr_nx = wr_ok ? wptr + ONE : wptr;
      // Oldest retained word moves once history spans DEPTH words
      org_nx  = (wr_ok && (wptr - org == FULL_CNT)) ? org + ONE : org;
      if (rewind)     rptr_nx = org_nx;
      else if (rd_ok) rptr_nx = rptr + ONE;
      else            rptr_nx = rptr;
      cnt_nx  = wptr_nx - rptr_nx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         org  <= '0;
      end else begin
         wptr <= wptr_nx;
         rptr <= rptr_nx;
         org  <= org_nx;
      end
   end

   // R5: a write on a full FIFO does not move the write side
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full_n) |=> $stable(wptr));

   // R6: a read on an empty FIFO (no rewind) does not move the read side
   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !empty_n && !rewind) |=> $stable(rptr));

   // R10: after a rewind the distance to replay never exceeds the depth
   a_r10_rewind_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rewind |=> ((wptr - rptr) <= FULL_CNT));

endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags
   import sfifo_pkg::*;
#(
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW:0]   cnt_nx,
   input  logic          ofs_ld,
   input  logic          ofs_sel,
   input  logic [AW-1:0] ofs_val,
   output sfifo_flags_t  flags
);

   localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
   localparam logic [AW:0]   HALF_CNT = (AW+1)'(DEPTH / 2);
   localparam logic [AW-1:0] DEF_OFS  = AW'(def_offset(DEPTH));

   logic [AW-1:0] n_q, m_q, n_nx, m_nx;
   sfifo_flags_t  flags_nx;

   assign n_nx = (ofs_ld && !ofs_sel) ? ofs_val : n_q;
   assign m_nx = (ofs_ld &&  ofs_sel) ? ofs_val : m_q;

   always_comb begin
      flags_nx.empty_n  = (cnt_nx != '0);
      flags_nx.aempty_n = (cnt_nx > {1'b0, n_nx});
      flags_nx.half_n   = (cnt_nx <= HALF_CNT);
      flags_nx.afull_n  = (cnt_nx < (FULL_CNT - {1'b0, m_nx}));
      flags_nx.full_n   = (cnt_nx != FULL_CNT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_q   <= DEF_OFS;
         m_q   <= DEF_OFS;
         flags <= '{empty_n: 1'b0, aempty_n: 1'b0, half_n: 1'b1,
                    afull_n: 1'b1, full_n: 1'b1};
      end else begin
         n_q   <= n_nx;
         m_q   <= m_nx;
         flags <= flags_nx;
      end
   end

   // R2: empty implies almost-empty
   a_r2_empty_in_aempty: assert property (@(posedge clk) disable iff (!rst_n)
      !flags.empty_n |-> !flags.aempty_n);

   // R4: full implies almost-full
   a_r4_full_in_afull: assert property (@(posedge clk) disable iff (!rst_n)
      !flags.full_n |-> !flags.afull_n);

   // R3: full implies past half
   a_r3_full_past_half: assert property (@(posedge clk) disable iff (!rst_n)
      !flags.full_n |-> !flags.half_n);

endmodule

// File: rtl/sfifo_pflag.sv
module sfifo_pflag
   import sfifo_pkg::*;
#(
   parameter int WIDTH = 18,
   parameter int DEPTH = 256
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [WIDTH-1:0]         wr_data,
   input  logic                     rd_en,
   output logic [WIDTH-1:0]         rd_data,
   input  logic                     rewind,
   input  logic                     ofs_ld,
   input  logic                     ofs_sel,
   input  logic [$clog2(DEPTH)-1:0] ofs_val,
   output logic                     empty_n,
   output logic                     aempty_n,
   output logic                     half_n,
   output logic                     afull_n,
   output logic                     full_n
);

   localparam int          AW       = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   generate
      if (DEPTH < 64 || DEPTH > 4096 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sfifo_pflag: DEPTH must be a power of two in 64..4096");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("sfifo_pflag: WIDTH must be positive");
      end
   endgenerate

   logic         wr_ok, rd_ok;
   logic [AW:0]  wptr, rptr, cnt_nx;
   sfifo_flags_t flags;

   sfifo_ptrs #(.DEPTH(DEPTH)) ptrs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .rewind  (rewind),
      .full_n  (flags.full_n),
      .empty_n (flags.empty_n),
      .wr_ok   (wr_ok),
      .rd_ok   (rd_ok),
      .wptr    (wptr),
      .rptr    (rptr),
      .cnt_nx  (cnt_nx)
   );

   sfifo_flags #(.DEPTH(DEPTH)) flags_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_nx  (cnt_nx),
      .ofs_ld  (ofs_ld),
      .ofs_sel (ofs_sel),
      .ofs_val (ofs_val),
      .flags   (flags)
   );

   sfifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) mem_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_ok),
      .waddr (wptr[AW-1:0]),
      .wdata (wr_data),
      .re    (rd_ok),
      .raddr (rptr[AW-1:0]),
      .rdata (rd_data)
   );

   assign empty_n  = flags.empty_n;
   assign aempty_n = flags.aempty_n;
   assign half_n   = flags.half_n;
   assign afull_n  = flags.afull_n;
   assign full_n   = flags.full_n;

   // R1: empty flag agrees with coinciding pointers
   a_r1_empty_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |-> (wptr == rptr));

   // R5: full flag agrees with pointers one depth apart
   a_r5_full_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> ((wptr - rptr) == FULL_CNT));

   // R6: read data holds when no read can be taken
   a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && empty_n && !rewind) |=> $stable(rd_data));

endmodule

// File: tb/sfifo_pflag_tb_top.sv
`timescale 1ns/1ps
module sfifo_pflag_tb_top;

   localparam int D  = 64;
   localparam int W  = 18;
   localparam int AW = $clog2(D);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en, rd_en, rewind, ofs_ld, ofs_sel;
   logic [W-1:0]  wr_data, rd_data;
   logic [AW-1:0] ofs_val;
   logic          empty_n, aempty_n, half_n, afull_n, full_n;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sfifo_pflag #(.WIDTH(W), .DEPTH(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .rewind(rewind),
      .ofs_ld(ofs_ld), .ofs_sel(ofs_sel), .ofs_val(ofs_val),
      .empty_n(empty_n), .aempty_n(aempty_n), .half_n(half_n),
      .afull_n(afull_n), .full_n(full_n));

   // ---------------- reference model ----------------
   logic [W-1:0] hist[$];
   int mw, mr, morg, mn, mm;
   logic [W-1:0] mq;

   // R7: default thresholds per depth
   function automatic int bench_def(int d);
      case (d)
         64:      return 7;
         128:     return 15;
         256:     return 31;
         512:     return 63;
         default: return 127;
      endcase
   endfunction

   function automatic int mcnt();
      return mw - mr;
   endfunction

   task automatic model_reset();
      hist.delete();
      mw = 0; mr = 0; morg = 0; mq = '0;
      mn = bench_def(D); mm = bench_def(D);
   endtask

   task automatic chk(string ph, string rq, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", ph, rq, got, exp);
      end
   endtask

   // R12: every flag is compared one edge after the stimulus that moves it
   task automatic check_all(string ph);
      int c = mcnt();
      chk(ph, "R1 empty_n",  int'(empty_n),  int'(c != 0));
      chk(ph, "R2 aempty_n", int'(aempty_n), int'(c > mn));
      chk(ph, "R3 half_n",   int'(half_n),   int'(c <= D/2));
      chk(ph, "R4 afull_n",  int'(afull_n),  int'(c < D - mm));
      chk(ph, "R5 full_n",   int'(full_n),   int'(c != D));
      chk(ph, "R9 rd_data",  int'(rd_data),  int'(mq));
   endtask

   // Apply one cycle at the falling edge, advance model, check at next falling edge
   task automatic cyc(string ph, bit wr, logic [W-1:0] din, bit rd, bit rw,
                      bit ld, bit sel, int val);
      bit full, empty, wok, rok;
      wr_en = wr; wr_data = din; rd_en = rd; rewind = rw;
      ofs_ld = ld; ofs_sel = sel; ofs_val = AW'(val);
      full  = (mcnt() == D);
      empty = (mcnt() == 0);
      wok   = wr && !full;
      rok   = rd && !empty && !rw;
      if (rok) begin mq = hist[mr]; mr++; end
      if (wok) begin
         if (mw - morg == D) morg++;
         hist.push_back(din); mw++;
      end
      if (rw) mr = morg;
      if (ld && !sel) mn = val;
      if (ld &&  sel) mm = val;
      @(negedge clk);
      check_all(ph);
   endtask

   task automatic do_reset(string ph);
      rst_n = 1'b0; wr_en = 0; rd_en = 0; rewind = 0; ofs_ld = 0;
      ofs_sel = 0; ofs_val = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
      check_all(ph);
   endtask

   // ---------------- watchdog ----------------
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000 && !done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0;
      @(negedge clk);
      do_reset("R7 reset");

      // R5: fill to full, then writes while full are dropped
      for (int i = 0; i < D; i++) cyc("R5 fill", 1, W'(i*3+1), 0, 0, 0, 0, 0);
      for (int i = 0; i < 4; i++) cyc("R5 overflow", 1, W'(18'h3ffff), 0, 0, 0, 0, 0);

      // R9: read part of the stream in order
      for (int i = 0; i < 10; i++) cyc("R9 read", 0, '0, 1, 0, 0, 0, 0);
      // R10: rewind with a read request on the same edge; replay all
      cyc("R10 rewind", 0, '0, 1, 1, 0, 0, 0);
      for (int i = 0; i < D; i++) cyc("R10 replay", 0, '0, 1, 0, 0, 0, 0);
      // R6: reads while empty are dropped
      for (int i = 0; i < 3; i++) cyc("R6 underflow", 0, '0, 1, 0, 0, 0, 0);

      // R11: rewind together with a write when history spans the depth
      cyc("R11 rewind+write", 1, W'(18'h2aaaa), 0, 1, 0, 0, 0);
      for (int i = 0; i < D; i++) cyc("R11 replay", 0, '0, 1, 0, 0, 0, 0);
      cyc("R11 rewind again", 0, '0, 0, 1, 0, 0, 0);
      for (int i = 0; i < D; i++) cyc("R11 replay2", 0, '0, 1, 0, 0, 0, 0);

      // R8: load thresholds, then sweep counts across them
      cyc("R8 load n", 0, '0, 0, 0, 1, 0, 20);
      cyc("R8 load m", 0, '0, 0, 0, 1, 1, 5);
      for (int i = 0; i < D; i++) cyc("R8 sweep up", 1, W'(i), 0, 0, 0, 0, 0);
      cyc("R8 load at full", 0, '0, 0, 0, 1, 1, 0);
      for (int i = 0; i < D; i++) cyc("R8 sweep down", 0, '0, 1, 0, 0, 0, 0);

      // R7: reset after loads brings back defaults
      do_reset("R7 re-reset");
      for (int i = 0; i < 10; i++) cyc("R7 defaults", 1, W'(i+100), 0, 0, 0, 0, 0);
      for (int i = 0; i < D; i++) cyc("R7 top", 1, W'(i+200), 0, 0, 0, 0, 0);

      // Random mix of all operations
      for (int i = 0; i < 4000; i++) begin
         int  ph = (i / 500) % 2;
         bit  w  = ($urandom % 100) < (ph ? 70 : 35);
         bit  r  = ($urandom % 100) < (ph ? 35 : 70);
         bit  rw = ($urandom % 100) < 2;
         bit  ld = ($urandom % 100) < 2;
         cyc("R10 R11 random", w, W'($urandom), r, rw, ld,
             1'($urandom % 2), int'($urandom % D));
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule